// File: doc/BRIEF.md
# RTC Interrupt Flag and Status Unit

This block keeps the interrupt flags of a real-time clock and drives its active-low interrupt request pin. Three kinds of event set the flags: a rising edge on one divider tap, picked by a 4-bit rate field, an alarm-match pulse and an update-complete pulse. A flag latches its event whether or not its enable is set. A registered summary bit is high whenever at least one flag and its own enable are both set, and that summary drives the pin low.

Software reads the block through a synchronous strobe and a one-bit register select. Select 0 is the interrupt status register: the summary bit is at bit 7, then the periodic, alarm and update flags at bits 6, 5 and 4, and bits 3 to 0 are always zero. A read of select 0 returns the values held before the read and clears all four bits together. Select 1 is the validity register: bit 7 shows the battery-good input, and the bit has no reset. The divider chain, the time counters and the alarm comparator sit outside the block.

Top module: `rtc_irq_status`

## Requirements
- R1: A status read (rd_sel = 0) returns the summary at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3:0 are always 0.
- R2: With rate_sel = 0 no periodic event occurs. With rate_sel = k (1 to 15), a 0-to-1 change of div_taps[k-1] between two clocks sets the periodic flag, whatever the state of en_periodic.
- R3: A one-cycle alarm_hit sets the alarm flag and a one-cycle update_done sets the update flag, whatever the state of their enables.
- R4: On each clock the summary bit loads the OR of (periodic AND en_periodic), (alarm AND en_alarm) and (update AND en_update), taken from the flag values after that edge. An enable raised while its flag is already 1 asserts the summary on the next clock.
- R5: irq_n is 0 exactly when the summary bit is 1.
- R6: On a status read, rd_data takes the four bits as they were before the edge, and the flags and the summary are cleared at that same edge. rd_data holds its value until the next read.
- R7: An event that arrives in the same cycle as a clearing status read leaves its flag set after the read.
- R8: A read of the validity register (rd_sel = 1) leaves the flags and irq_n unchanged.
- R9: A validity read returns batt_good at bit 7 and 0 at bits 6:0. Reset has no effect on it.
- R10: A synchronous reset (rst_n = 0) clears the flags, the summary and rd_data, so irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_taps | input | 15 | Divider chain taps; bit k-1 is chosen by rate_sel = k |
| rate_sel | input | 4 | Periodic rate select; 0 turns periodic events off |
| alarm_hit | input | 1 | One-cycle alarm-match pulse |
| update_done | input | 1 | One-cycle update-complete pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update interrupt enable |
| rd_stb | input | 1 | Read strobe, sampled on the clock |
| rd_sel | input | 1 | Register select: 0 status, 1 validity |
| batt_good | input | 1 | Battery-good level |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands in the very cycle a status read clears the flags. A periodic edge falls at a time set by the divider, so the directed stimulus uses the alarm input instead, raising alarm_hit in the same cycle as the read strobe. It then checks that this read returns the old value and that the next read returns the alarm bit. A long random phase then drives all events, enables, rate changes and both reads at once. Every clock, rd_data and irq_n are compared against a behavioural model, so coincidences that the directed part does not aim for are still covered.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths, register selects and flag positions for the
// RTC interrupt unit. Flag vector index order matches status bits 6..4.
package rtc_irq_pkg;
    localparam int RATE_W   = 4;
    localparam int NUM_TAPS = (1 << RATE_W) - 1;
    localparam int FLAG_N   = 3;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 1;

    localparam logic [SEL_W-1:0] SEL_STATUS = 1'b0;
    localparam logic [SEL_W-1:0] SEL_VALID  = 1'b1;

    // flag vector indices (status bit = 4 + index)
    localparam int F_UPD = 0;
    localparam int F_ALM = 1;
    localparam int F_PER = 2;
endpackage

// File: rtl/rtc_tap_edge.sv
// Module: picks one divider tap by the rate field and turns its rising
// edge into a one-cycle pulse. Assumes taps are synchronous to clk.
// A rate of zero selects a constant 0, so no event is produced.
module rtc_tap_edge
    import rtc_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [RATE_W-1:0]   rate,
    output logic                pulse
);
    logic [NUM_TAPS:0] tap_ext;
    logic              tap_now;
    logic              tap_prev;

    // Tap mux: index 0 is the forced-off position.
    always_comb begin
        tap_ext = {taps, 1'b0};
        tap_now = tap_ext[rate];
    end

    // Remember last cycle's selected tap level.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_prev <= 1'b0;
        else        tap_prev <= tap_now;
    end

    // Rising-edge pulse.
    assign pulse = tap_now & ~tap_prev;
endmodule

// File: rtl/rtc_flag_bank.sv
// Module: sticky event flags plus the registered masked summary.
// A clear and a same-cycle event resolve to set (event wins).
module rtc_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] events,
    input  logic [FLAG_N-1:0] enables,
    input  logic              clear,
    output logic [FLAG_N-1:0] flags,
    output logic              summary
);
    logic [FLAG_N-1:0] flags_d;

    // One sticky bit per event source.
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        // Next value: keep unless cleared, then OR the new event.
        always_comb flags_d[i] = (flags[i] & ~clear) | events[i];

        // Flag storage with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= flags_d[i];
        end
    end

    // Summary tracks next-state flags masked by the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) summary <= 1'b0;
        else        summary <= |(flags_d & enables);
    end
endmodule

// File: rtl/rtc_reg_read.sv
// Module: registered read port. Captures the selected register on a
// strobe and holds it otherwise. Validity source is a live level with
// no reset dependence.
module rtc_reg_read
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              summary,
    input  logic [FLAG_N-1:0] flags,
    input  logic              batt_good,
    output logic [DATA_W-1:0] rd_data,
    output logic              clear
);
    localparam int PAD_LO = DATA_W - 1 - FLAG_N;

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] valid_word;

    // Assemble both register images.
    always_comb begin
        status_word = {summary, flags, {PAD_LO{1'b0}}};
        valid_word  = {batt_good, {(DATA_W-1){1'b0}}};
    end

    // Status read requests a flag clear at this edge.
    assign clear = rd_stb && (rd_sel == SEL_STATUS);

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= (rd_sel == SEL_STATUS) ? status_word : valid_word;
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Module: top of the RTC interrupt unit. Wires the tap edge detector,
// the flag bank and the read port, and drives the active-low pin.
// Assumes all inputs are synchronous to clk.
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] div_taps,
    input  logic [RATE_W-1:0]   rate_sel,
    input  logic                alarm_hit,
    input  logic                update_done,
    input  logic                en_periodic,
    input  logic                en_alarm,
    input  logic                en_update,
    input  logic                rd_stb,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic                batt_good,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq_n
);
    logic              tap_event;
    logic [FLAG_N-1:0] evt_vec;
    logic [FLAG_N-1:0] en_vec;
    logic [FLAG_N-1:0] flags;
    logic              summary;
    logic              clear;

    rtc_tap_edge u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (div_taps),
        .rate  (rate_sel),
        .pulse (tap_event)
    );

    // Pack events and enables in flag index order.
    always_comb begin
        evt_vec        = '0;
        en_vec         = '0;
        evt_vec[F_PER] = tap_event;
        evt_vec[F_ALM] = alarm_hit;
        evt_vec[F_UPD] = update_done;
        en_vec[F_PER]  = en_periodic;
        en_vec[F_ALM]  = en_alarm;
        en_vec[F_UPD]  = en_update;
    end

    rtc_flag_bank u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (evt_vec),
        .enables (en_vec),
        .clear   (clear),
        .flags   (flags),
        .summary (summary)
    );

    rtc_reg_read u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .rd_sel    (rd_sel),
        .summary   (summary),
        .flags     (flags),
        .batt_good (batt_good),
        .rd_data   (rd_data),
        .clear     (clear)
    );

    // Active-low request pin.
    assign irq_n = ~summary;
endmodule

// File: rtl/rtc_irq_status_chk.sv
// Checker: temporal properties on the top's ports and the tap pulse.
module rtc_irq_status_chk
    import rtc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tap_event,
    input logic              alarm_hit,
    input logic              update_done,
    input logic              en_alarm,
    input logic              rd_stb,
    input logic [SEL_W-1:0]  rd_sel,
    input logic              batt_good,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_n
);
    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3:0] == 4'b0);

    p_alarm_raises_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hit && en_alarm && !(rd_stb && rd_sel == SEL_STATUS)) |=> !irq_n);

    p_clear_releases_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == SEL_STATUS && !alarm_hit && !update_done && !tap_event) |=> irq_n);

    p_data_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    p_valid_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel == SEL_VALID) |=> (rd_data == {$past(batt_good), 7'b0}));

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (irq_n && rd_data == '0));
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_event   (tap_event),
    .alarm_hit   (alarm_hit),
    .update_done (update_done),
    .en_alarm    (en_alarm),
    .rd_stb      (rd_stb),
    .rd_sel      (rd_sel),
    .batt_good   (batt_good),
    .rd_data     (rd_data),
    .irq_n       (irq_n)
);

// File: tb/rtc_irq_status_test.sv
// Bench: behavioural per-clock model compared on every falling edge,
// plus directed checks for each requirement.
module rtc_irq_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] div_taps = '0;
    logic [3:0]  rate_sel = '0;
    logic        alarm_hit = 0, update_done = 0;
    logic        en_periodic = 0, en_alarm = 0, en_update = 0;
    logic        rd_stb = 0;
    logic [0:0]  rd_sel = '0;
    logic        batt_good = 1'b1;
    logic [7:0]  rd_data;
    logic        irq_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    bit free_taps = 1;

    // model state
    int m_pf = 0, m_af = 0, m_uf = 0, m_irq = 0, m_prev = 0;
    int m_rd = 0;

    always #5 clk = ~clk;

    rtc_irq_status uut (
        .clk(clk), .rst_n(rst_n), .div_taps(div_taps), .rate_sel(rate_sel),
        .alarm_hit(alarm_hit), .update_done(update_done),
        .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
        .rd_stb(rd_stb), .rd_sel(rd_sel), .batt_good(batt_good),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    // Free-running divider stand-in.
    always @(negedge clk) if (free_taps) div_taps <= div_taps + 15'd1;

    // Reference model, evaluated on each rising edge.
    always @(posedge clk) begin
        int tap, pev, clr;
        if (!rst_n) begin
            m_pf = 0; m_af = 0; m_uf = 0; m_irq = 0; m_prev = 0; m_rd = 0;
        end else begin
            tap = (rate_sel == 0) ? 0 : int'(div_taps[rate_sel - 4'd1]);
            pev = (tap == 1 && m_prev == 0) ? 1 : 0;
            m_prev = tap;
            clr = (rd_stb && rd_sel == 1'b0) ? 1 : 0;
            if (rd_stb)
                m_rd = (rd_sel == 1'b0) ? (m_irq*128 + m_pf*64 + m_af*32 + m_uf*16)
                                        : (batt_good ? 128 : 0);
            if (clr) begin m_pf = 0; m_af = 0; m_uf = 0; end
            if (pev) m_pf = 1;
            if (alarm_hit) m_af = 1;
            if (update_done) m_uf = 1;
            m_irq = ((m_pf && en_periodic) || (m_af && en_alarm) || (m_uf && en_update)) ? 1 : 0;
        end
    end

    // Per-clock comparison (R1, R4, R5, R6).
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (irq_n !== (m_irq == 0)) begin
                errors++;
                $display("FAIL R4/R5 irq_n got %b exp %b at %0t", irq_n, (m_irq == 0), $time);
            end
            if (rd_data !== 8'(m_rd)) begin
                errors++;
                $display("FAIL R1/R6 rd_data got %h exp %h at %0t", rd_data, 8'(m_rd), $time);
            end
        end
    end

    task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string req);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Single read; returns after rd_data has been updated.
    task automatic do_read(input logic sel);
        rd_stb = 1; rd_sel = sel;
        @(negedge clk);
        rd_stb = 0;
    endtask

    initial begin
        tick(3);
        // R10: reset state
        check8({7'b0, irq_n}, 8'h01, "R10 irq_n after reset");
        check8(rd_data, 8'h00, "R10 rd_data after reset");
        rst_n = 1;
        tick(1);
        // R9: validity follows battery level
        do_read(1'b1); check8(rd_data, 8'h80, "R9 valid good");
        batt_good = 0;
        do_read(1'b1); check8(rd_data, 8'h00, "R9 valid bad");
        batt_good = 1;
        // R3: alarm latches with enable off, pin idle
        alarm_hit = 1; tick(1); alarm_hit = 0; tick(2);
        check8({7'b0, irq_n}, 8'h01, "R3/R5 pin idle when masked");
        do_read(1'b0); check8(rd_data, 8'h20, "R1/R3 alarm flag");
        do_read(1'b0); check8(rd_data, 8'h00, "R6 flags cleared");
        // R4: late enable asserts the pin next clock
        update_done = 1; tick(1); update_done = 0; tick(1);
        en_update = 1; tick(1);
        check8({7'b0, irq_n}, 8'h00, "R4 late enable");
        // R8: validity read leaves request alone
        do_read(1'b1); tick(1);
        check8({7'b0, irq_n}, 8'h00, "R8 pin after valid read");
        do_read(1'b0); check8(rd_data, 8'h90, "R6 pre-clear value");
        check8({7'b0, irq_n}, 8'h01, "R6 pin released");
        en_update = 0;
        // R7: event coincident with clearing read
        alarm_hit = 1; rd_stb = 1; rd_sel = 1'b0; tick(1);
        alarm_hit = 0; rd_stb = 0;
        check8(rd_data, 8'h00, "R7 read shows old value");
        do_read(1'b0); check8(rd_data, 8'h20, "R7 alarm kept");
        // R2: rate 0 gives nothing
        tick(40); do_read(1'b0); check8(rd_data, 8'h00, "R2 rate zero");
        // R2: periodic with enable off then on
        rate_sel = 4'd3; tick(20); rate_sel = 4'd0; tick(1);
        do_read(1'b0); check8(rd_data, 8'h40, "R2 periodic masked");
        en_periodic = 1; rate_sel = 4'd2; tick(10); rate_sel = 4'd0; tick(1);
        check8({7'b0, irq_n}, 8'h00, "R2/R5 periodic irq");
        // R10/R9: reset with flags set, validity still readable
        rst_n = 0; tick(2); rst_n = 1; tick(1);
        do_read(1'b1); check8(rd_data, 8'h80, "R9 valid after reset");
        do_read(1'b0); check8(rd_data, 8'h00, "R10 flags cleared by reset");
        en_periodic = 0;
        // Random mix over all inputs.
        for (int i = 0; i < 3000; i++) begin
            alarm_hit   = ($urandom_range(0, 9) == 0);
            update_done = ($urandom_range(0, 9) == 0);
            rd_stb      = ($urandom_range(0, 3) == 0);
            rd_sel      = 1'($urandom_range(0, 1));
            en_periodic = 1'($urandom_range(0, 1));
            en_alarm    = 1'($urandom_range(0, 1));
            en_update   = 1'($urandom_range(0, 1));
            batt_good   = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 49) == 0) rate_sel = 4'($urandom_range(0, 15));
            rst_n       = ($urandom_range(0, 199) != 0);
            tick(1);
        end
        rst_n = 1; rd_stb = 0; alarm_hit = 0; update_done = 0;
        tick(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(100000 * 10);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule